// File: doc/BRIEF.md
# Pipelined Burst Word-RAM Slave

A memory-mapped slave that holds a word-wide RAM. A master presents a byte address, a read or write strobe, write data, byte lanes and a beat count. The slave answers reads through a fixed-depth pipeline, so several reads can be in flight at once. Each returned word is marked by a response-valid flag. That flag comes only from the pipeline and never from the request pins of the same cycle.

Back-pressure works as an inverted ready. While `stall` is high the master keeps every request pin steady, and nothing is consumed. A request is taken at a clock edge where it is presented with `stall` low. There is no back-pressure on responses: the master must accept one word per cycle whenever `rsp_valid` is high. Bursts increment one word per beat and wrap within the RAM. A read burst keeps `stall` high while its beats are issued internally. During a write burst `stall` stays low, and each cycle with `req_wr` high supplies one data beat.

Top module: `burst_ram_slave`

## Requirements
- R1: `req_addr` is a byte address. The word index is `req_addr` with its low log2(DATA_W/8) bits removed (bits [1:0] with 32-bit data). A read returns the word last written at that index.
- R2: A request is consumed only at an edge where `stall` is low. A read held under `stall` is taken later with its data intact and does not raise the pending count while stalled.
- R3: Responses come in request order. A read beat issued internally at edge E is shown on `rsp_data` with `rsp_valid` high during the cycle that follows edge E+RD_STAGES-1. Single reads on consecutive cycles are accepted without stall while capacity allows.
- R4: `rsp_valid` is high only while a read is pending. It is never raised for a rejected request or after reset.
- R5: On writes, bit i of `req_be` enables byte lane i, which is data bits [8i+7:8i]. Disabled lanes keep their old content.
- R6: A request is rejected if its address low bits are nonzero, its count is 0, or its count exceeds CAP. A rejected read gives no response. A rejected write stores nothing, and its remaining count-1 beats are taken and dropped.
- R7: A read burst of N beats yields exactly N responses on consecutive cycles, from consecutive word indices that wrap modulo the RAM depth. `stall` is high for the N-1 cycles after acceptance.
- R8: A write burst takes its address on the first beat. Each later accepted beat writes the next word index, with wrap, until N beats are done, and `stall` stays low between beats.
- R9: The count of pending read beats never exceeds CAP. A valid read of N beats is stalled while pending+N > CAP.
- R10: After synchronous reset, `stall` and `rsp_valid` are low and no read is pending. A reset also drops any reads in flight.
- R11: When `req_rd` and `req_wr` are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | ADDR_W | Byte address of the first beat |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request or write data beat |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables for writes |
| req_burst | input | BURST_W | Beat count, plain binary |
| stall | output | 1 | High: request not taken, hold pins |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | DATA_W | Response word |

## Verification
The bench builds the slave with ADDR_W=6 (16 words), DATA_W=32, BURST_W=4, RD_STAGES=3 and CAP=8. With only 16 words, every start address can be paired with every legal burst length from 1 to 8, so wrap-around at the top of the RAM is exercised on both reads and writes. It also sweeps all 16 byte-enable patterns and all three misaligned offsets. With CAP close to the burst length, two back-to-back 8-beat reads hit the capacity stall, and the bench checks the exact edge at which the second read is accepted.

// File: rtl/burst_ram_pkg.sv
package burst_ram_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/burst_ram_seq.sv
module burst_ram_seq
  import burst_ram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFF_W   = 2,
  parameter int BURST_W = 4,
  parameter int CAP     = 8,
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int PEND_W = $clog2(CAP + 1),
  localparam int SUM_W  = ((PEND_W > BURST_W) ? PEND_W : BURST_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [BURST_W-1:0] req_burst,
  input  logic              rsp_valid,
  output logic              stall,
  output logic              iss_valid,
  output logic [WORD_W-1:0] iss_word,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [PEND_W-1:0] pend_cnt,
  output logic              busy
);
  seq_state_e state_q, state_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [WORD_W-1:0]  ptr_q, ptr_d;
  logic               drop_q, drop_d;
  logic [PEND_W-1:0]  pend_q, pend_d;
  logic [WORD_W-1:0]  req_word;
  logic               fmt_ok, room_ok, rd_take, multi;

  assign req_word = req_addr[ADDR_W-1:OFF_W];
  assign multi    = req_burst > BURST_W'(1);
  assign fmt_ok   = (req_addr[OFF_W-1:0] == '0) && (req_burst != '0) &&
                    (SUM_W'(req_burst) <= SUM_W'(CAP));
  assign room_ok  = (SUM_W'(pend_q) + SUM_W'(req_burst)) <= SUM_W'(CAP);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    drop_d    = drop_q;
    stall     = 1'b0;
    iss_valid = 1'b0;
    iss_word  = req_word;
    wr_en     = 1'b0;
    wr_word   = req_word;
    rd_take   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (req_wr) begin
          wr_en = fmt_ok;
          if (multi) begin
            state_d = SEQ_WR;
            cnt_d   = req_burst - BURST_W'(1);
            ptr_d   = req_word + WORD_W'(1);
            drop_d  = !fmt_ok;
          end
        end else if (req_rd && fmt_ok) begin
          if (!room_ok) begin
            stall = 1'b1;
          end else begin
            rd_take   = 1'b1;
            iss_valid = 1'b1;
            if (multi) begin
              state_d = SEQ_RD;
              cnt_d   = req_burst - BURST_W'(1);
              ptr_d   = req_word + WORD_W'(1);
            end
          end
        end
      end
      SEQ_RD: begin
        stall     = 1'b1;
        iss_valid = 1'b1;
        iss_word  = ptr_q;
        ptr_d     = ptr_q + WORD_W'(1);
        cnt_d     = cnt_q - BURST_W'(1);
        if (cnt_q == BURST_W'(1)) state_d = SEQ_IDLE;
      end
      SEQ_WR: begin
        if (req_wr) begin
          wr_en   = !drop_q;
          wr_word = ptr_q;
          ptr_d   = ptr_q + WORD_W'(1);
          cnt_d   = cnt_q - BURST_W'(1);
          if (cnt_q == BURST_W'(1)) state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    pend_d = PEND_W'(SUM_W'(pend_q) + (rd_take ? SUM_W'(req_burst) : SUM_W'(0))
                     - SUM_W'(rsp_valid));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      drop_q  <= 1'b0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      drop_q  <= drop_d;
      pend_q  <= pend_d;
    end
  end

  assign pend_cnt = pend_q;
  assign busy     = (state_q != SEQ_IDLE);
endmodule

// File: rtl/burst_ram_array.sv
module burst_ram_array #(
  parameter int WORD_W = 6,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic              iss_valid,
  input  logic [WORD_W-1:0] iss_word,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              s0_valid;
  logic [WORD_W-1:0] s0_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s0_valid  <= iss_valid;
      out_valid <= s0_valid;
    end
    s0_word <= iss_word;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) lane_mem[wr_word] <= wr_data[g*8 +: 8];
      rd_q <= lane_mem[s0_word];
    end
    assign out_data[g*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/burst_ram_delay.sv
module burst_ram_delay #(
  parameter int DATA_W = 32,
  parameter int EXTRA  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  if (EXTRA == 0) begin : g_pass
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end else begin : g_regs
    logic [EXTRA-1:0]             v_q;
    logic [EXTRA-1:0][DATA_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) v_q <= '0;
      else begin
        v_q[0] <= in_valid;
        for (int i = 1; i < EXTRA; i++) v_q[i] <= v_q[i-1];
      end
      d_q[0] <= in_data;
      for (int i = 1; i < EXTRA; i++) d_q[i] <= d_q[i-1];
    end
    assign out_valid = v_q[EXTRA-1];
    assign out_data  = d_q[EXTRA-1];
  end
endmodule

// File: rtl/burst_ram_slave.sv
module burst_ram_slave #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BURST_W   = 4,
  parameter int RD_STAGES = 3,
  parameter int CAP       = 8,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int PEND_W = $clog2(CAP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  input  logic [BURST_W-1:0] req_burst,
  output logic               stall,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  logic              iss_valid, wr_en, arr_valid, seq_busy;
  logic [WORD_W-1:0] iss_word, wr_word;
  logic [DATA_W-1:0] arr_data;
  logic [PEND_W-1:0] pend_cnt;
  logic [OFF_W-1:0]  req_off;

  assign req_off = req_addr[OFF_W-1:0];

  burst_ram_seq #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BURST_W(BURST_W), .CAP(CAP)
  ) seq_i (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd),
    .req_wr(req_wr), .req_burst(req_burst), .rsp_valid(rsp_valid),
    .stall(stall), .iss_valid(iss_valid), .iss_word(iss_word),
    .wr_en(wr_en), .wr_word(wr_word), .pend_cnt(pend_cnt), .busy(seq_busy)
  );

  burst_ram_array #(.WORD_W(WORD_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(req_wdata), .wr_be(req_be), .iss_valid(iss_valid),
    .iss_word(iss_word), .out_valid(arr_valid), .out_data(arr_data)
  );

  burst_ram_delay #(.DATA_W(DATA_W), .EXTRA(RD_STAGES - 2)) dly_i (
    .clk(clk), .rst(rst), .in_valid(arr_valid), .in_data(arr_data),
    .out_valid(rsp_valid), .out_data(rsp_data)
  );
endmodule

// File: rtl/burst_ram_slave_chk.sv
module burst_ram_slave_chk #(
  parameter int BURST_W = 4,
  parameter int CAP     = 8,
  parameter int OFF_W   = 2,
  localparam int PEND_W = $clog2(CAP + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_rd,
  input logic               req_wr,
  input logic [OFF_W-1:0]   req_off,
  input logic [BURST_W-1:0] req_burst,
  input logic               stall,
  input logic               rsp_valid,
  input logic [PEND_W-1:0]  pend_cnt,
  input logic               busy
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      a_reset_quiet_r10: assert (!rsp_valid && !stall && pend_cnt == '0)
        else $error("reset state wrong");
    end
  end

  p_pend_bound_r9: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= CAP);

  p_rsp_needs_pending_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pend_cnt != '0);

  p_stalled_read_no_growth_r2: assert property (@(posedge clk) disable iff (rst)
    (req_rd && stall) |=> pend_cnt <= $past(pend_cnt));

  p_reject_no_growth_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_rd && !req_wr && req_off != '0) |=> pend_cnt <= $past(pend_cnt));

  p_burst_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_rd && !req_wr && !stall && req_off == '0 &&
     req_burst > BURST_W'(1) && 32'(req_burst) <= CAP) |=> stall);
endmodule

bind burst_ram_slave burst_ram_slave_chk #(
  .BURST_W(BURST_W), .CAP(CAP), .OFF_W(OFF_W)
) chk_i (
  .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_off(req_off),
  .req_burst(req_burst), .stall(stall), .rsp_valid(rsp_valid),
  .pend_cnt(pend_cnt), .busy(seq_busy)
);

// File: tb/burst_ram_slave_tb_top.sv
module burst_ram_slave_tb_top;
  localparam int AW = 6, BW = 4, ST = 3, CP = 8, WORDS = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_rd = 1'b0, req_wr = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic [BW-1:0] req_burst = '0;
  logic stall, rsp_valid;
  logic [31:0] rsp_data;

  burst_ram_slave #(.ADDR_W(AW), .DATA_W(32), .BURST_W(BW), .RD_STAGES(ST), .CAP(CP)) dut_i (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
    .req_wdata(req_wdata), .req_be(req_be), .req_burst(req_burst),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0, rsp_seen = 0;
  bit done = 1'b0;
  logic [31:0] ref_mem [WORDS];
  logic [31:0] exp_q[$];
  int expc_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int b);
    return (32'(a + 1) * 32'h9E3779B9) ^ (32'(b) << 16) ^ 32'(b * 7 + 3);
  endfunction

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      rsp_seen++;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected response", rsp_data, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic int ec = expc_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
        check(cyc == ec, "R3 latency", 32'(cyc), 32'(ec));
      end
    end
  end

  task automatic put_req(input bit rd, input bit wr, input int addr, input int n,
                         input logic [3:0] be, input logic [31:0] d, output int acc);
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_addr = addr[AW-1:0]; req_burst = n[BW-1:0];
    req_be = be; req_wdata = d;
    #1;
    while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc = cyc;
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  function automatic bit legal(input int addr, input int n);
    return (addr % 4 == 0) && n >= 1 && n <= CP;
  endfunction

  task automatic wr_burst(input int addr, input int n, input int seed);
    int acc;
    int beats = (n > 1) ? n : 1;
    for (int k = 0; k < beats; k++) begin
      put_req(1'b0, 1'b1, addr, n, 4'hF, pat(seed, k), acc);
      if (legal(addr, n)) ref_mem[(addr / 4 + k) % WORDS] = pat(seed, k);
    end
  endtask

  task automatic rd_burst(input int addr, input int n, input string tag, output int acc);
    put_req(1'b1, 1'b0, addr, n, 4'h0, 32'h0, acc);
    if (legal(addr, n)) begin
      check(exp_q.size() + n <= CP, "R9 capacity at accept", 32'(exp_q.size()), 32'(CP - n));
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(ref_mem[(addr / 4 + k) % WORDS]);
        expc_q.push_back(acc + k + ST - 1);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 200) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int acc, acc2, seen0;
    int accs [8];
    logic [31:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!stall && !rsp_valid, "R10 reset outputs", {30'h0, stall, rsp_valid}, 32'h0);

    // R1: single writes and reads over every word
    for (int w = 0; w < WORDS; w++) wr_burst(4 * w, 1, 100 + w);
    for (int w = 0; w < WORDS; w++) rd_burst(4 * w, 1, "R1 single read", acc);
    drain();

    // R3: back-to-back single reads, no stall below capacity
    for (int k = 0; k < 8; k++) rd_burst(4 * k, 1, "R3 pipelined read", accs[k]);
    for (int k = 1; k < 8; k++) check(accs[k] == accs[0] + k, "R3 back-to-back accept", 32'(accs[k]), 32'(accs[0] + k));
    drain();

    // R7 / R8: every legal length at every start, with wrap
    for (int n = 1; n <= CP; n++)
      for (int s = 0; s < WORDS; s++) begin
        wr_burst(4 * s, n, 1000 + n * 32 + s);
        rd_burst(4 * s, n, (n > 1) ? "R8 write burst readback" : "R7 burst read", acc);
        drain();
      end
    for (int s = 0; s < WORDS; s += 3) begin
      rd_burst(4 * s, CP, "R7 burst read wrap", acc);
      drain();
    end

    // R5: all byte-enable patterns
    for (int be = 0; be < 16; be++) begin
      int w = be % WORDS;
      wr_burst(4 * w, 1, 5000 + be);
      put_req(1'b0, 1'b1, 4 * w, 1, be[3:0], 32'hC3A5_5A3C ^ 32'(be), acc);
      m = ref_mem[w];
      for (int l = 0; l < 4; l++) if (be[l]) m[8*l +: 8] = (32'hC3A5_5A3C ^ 32'(be)) >> (8 * l);
      ref_mem[w] = m;
      rd_burst(4 * w, 1, "R5 byte lanes", acc);
      drain();
    end

    // R6: rejected writes and reads
    for (int off = 1; off < 4; off++) begin
      wr_burst(4 * 5 + off, 2, 7000 + off);
      seen0 = rsp_seen;
      rd_burst(4 * 5 + off, 1, "R6 misaligned read", acc);
      repeat (8) @(negedge clk);
      check(rsp_seen == seen0, "R6 misaligned read silent", 32'(rsp_seen), 32'(seen0));
      rd_burst(4 * 5, 2, "R6 misaligned write left memory", acc);
      drain();
    end
    seen0 = rsp_seen;
    rd_burst(0, 0, "R6 zero count", acc);
    rd_burst(0, 9, "R6 over cap", acc);
    wr_burst(4 * 2, 9, 7100);
    wr_burst(4 * 3, 0, 7200);
    repeat (8) @(negedge clk);
    check(rsp_seen == seen0, "R6 bad count silent", 32'(rsp_seen), 32'(seen0));
    rd_burst(0, 8, "R6 bad count left memory", acc);
    drain();

    // R11: read and write together, write wins
    seen0 = rsp_seen;
    put_req(1'b1, 1'b1, 4 * 9, 1, 4'hF, 32'hDEAD_BEEF, acc);
    ref_mem[9] = 32'hDEAD_BEEF;
    repeat (8) @(negedge clk);
    check(rsp_seen == seen0, "R11 read ignored", 32'(rsp_seen), 32'(seen0));
    rd_burst(4 * 9, 1, "R11 write performed", acc);
    drain();

    // R9 / R2: capacity stall on two full bursts
    rd_burst(0, CP, "R2 first full burst", acc);
    rd_burst(4 * 4, CP, "R2 stalled burst data", acc2);
    check(acc2 == acc + CP + ST, "R9 stalled until drained", 32'(acc2), 32'(acc + CP + ST));
    drain();

    // R10: reset drops reads in flight
    rd_burst(0, CP, "R10 unused", acc);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_q.delete(); expc_q.delete(); tag_q.delete();
    seen0 = rsp_seen;
    #1;
    check(!stall && !rsp_valid, "R10 after mid-flight reset", {30'h0, stall, rsp_valid}, 32'h0);
    repeat (12) @(negedge clk);
    check(rsp_seen == seen0, "R4 no response after reset", 32'(rsp_seen), 32'(seen0));
    rd_burst(4 * 9, 1, "R10 memory kept", acc);
    drain();

    check(exp_q.size() == 0, "R3 all responses returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule